// File: doc/BRIEF.md
# Register File with Shadow Custom Registers

This block is the architectural register file of a single-issue, in-order RISC core. It is extended with a small bank of custom registers that sit beside the custom-instruction logic. The generic file has two combinational read ports and one write-back port. On any write-back, a side-copy enable and an index can duplicate the same result into one custom register on the same clock edge.

A move command copies a custom register back into a generic register. The compiler can therefore park a value that would otherwise be spilled to memory and later restore it without a load. The whole custom bank is also presented as flat output taps, which supply extra operands to custom-instruction hardware beyond the two generic read ports.

Reads are combinational and forward same-cycle writes. Register 0 is hard-wired to zero. When the move and a normal write-back aim at the same generic register, the write-back takes priority.

Top module: `shadow_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every generic and every custom register to zero on the clock edge where it is sampled high.
- R2: The generic file holds NGEN (default 32) registers. A write-back with `wb_en` high and `wb_idx` not zero stores `wb_data` on the next rising edge. Both read ports return the stored value combinationally.
- R3: Generic register 0 always reads as zero. A write-back to index 0 and a move targeting index 0 both leave every register unchanged.
- R4: When `wb_en` and `wb_shd_en` are both high, `wb_data` is copied into custom register `wb_shd_idx` on the same edge as the generic write. This copy happens even if `wb_idx` is 0. With `wb_en` low, `wb_shd_en` has no effect.
- R5: A `wb_shd_idx` of NSHD or above changes no custom register, and the generic write still happens.
- R6: A custom register keeps its value across any number of cycles and moves until the next side copy into it.
- R7: With `mv_en` high, custom register `mv_src` is copied into generic register `mv_dst` on the next edge. A `mv_src` of NSHD or above drops the move.
- R8: If `wb_en` is high and `wb_idx` equals a nonzero `mv_dst` in the same cycle, the generic register receives `wb_data` and the move is dropped.
- R9: A read port whose index matches a same-cycle write-back or an accepted move returns the value being written, not the stored one.
- R10: Custom register i is presented at `shd_taps[i*XLEN +: XLEN]`. During a side copy into register i, that tap already shows `wb_data`.
- R11: A move whose source is being side-copied in the same cycle transfers the new `wb_data`, that is, the value its tap shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | GW | Read port A register index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | GW | Read port B register index |
| rd_b_data | output | XLEN | Read port B data |
| wb_en | input | 1 | Generic write-back enable |
| wb_idx | input | GW | Write-back destination index |
| wb_data | input | XLEN | Write-back result value |
| wb_shd_en | input | 1 | Also copy the result into a custom register |
| wb_shd_idx | input | SW | Custom register chosen for the side copy |
| mv_en | input | 1 | Move custom register to generic register |
| mv_src | input | SW | Custom register read by the move |
| mv_dst | input | GW | Generic register written by the move |
| shd_taps | output | NSHD*XLEN | All custom registers, register i at bits i*XLEN upward |

## Verification
On every cycle, the assertions check several state properties: reset clearing both banks, write-back and side copy landing on the following edge, custom registers staying unchanged without a side copy, and an accepted move depositing its source value. The bench runs a behavioural model against every read port and tap on every clock. That comparison is what exposes the same-cycle effects: forwarding on reads and taps, write-back winning over a move to the same target, moves seeing a same-cycle side copy, and out-of-range custom indices being ignored. The bench uses three custom registers, so an out-of-range index actually exists.

// File: rtl/shadow_regfile.sv
`timescale 1ns/1ps
module shadow_regfile #(
  parameter int XLEN = 32,
  parameter int NGEN = 32,
  parameter int NSHD = 4,
  localparam int GW = $clog2(NGEN),
  localparam int SW = (NSHD > 1) ? $clog2(NSHD) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GW-1:0]        rd_a_idx,
  output logic [XLEN-1:0]      rd_a_data,
  input  logic [GW-1:0]        rd_b_idx,
  output logic [XLEN-1:0]      rd_b_data,
  input  logic                 wb_en,
  input  logic [GW-1:0]        wb_idx,
  input  logic [XLEN-1:0]      wb_data,
  input  logic                 wb_shd_en,
  input  logic [SW-1:0]        wb_shd_idx,
  input  logic                 mv_en,
  input  logic [SW-1:0]        mv_src,
  input  logic [GW-1:0]        mv_dst,
  output logic [NSHD*XLEN-1:0] shd_taps
);

  logic [NGEN-1:0][XLEN-1:0] gen_q;
  logic [NSHD-1:0][XLEN-1:0] shd_q;
  logic [NSHD-1:0][XLEN-1:0] tap_w;

  logic wb_ok, shd_ok, src_ok, mv_ok;
  logic [XLEN-1:0] mv_val;

  assign wb_ok  = wb_en && (wb_idx != '0);
  assign shd_ok = wb_en && wb_shd_en && (32'(wb_shd_idx) < NSHD);
  assign src_ok = 32'(mv_src) < NSHD;
  assign mv_ok  = mv_en && src_ok && (mv_dst != '0) && !(wb_en && (wb_idx == mv_dst));

  for (genvar i = 0; i < NSHD; i++) begin : g_tap
    assign tap_w[i] = (shd_ok && (32'(wb_shd_idx) == i)) ? wb_data : shd_q[i];
    assign shd_taps[i*XLEN +: XLEN] = tap_w[i];
  end

  always_comb begin
    mv_val = '0;
    for (int i = 0; i < NSHD; i++)
      if (32'(mv_src) == i) mv_val = tap_w[i];
  end

  assign rd_a_data = (rd_a_idx == '0)                 ? '0      :
                     (wb_ok && (wb_idx == rd_a_idx))  ? wb_data :
                     (mv_ok && (mv_dst == rd_a_idx))  ? mv_val  : gen_q[rd_a_idx];
  assign rd_b_data = (rd_b_idx == '0)                 ? '0      :
                     (wb_ok && (wb_idx == rd_b_idx))  ? wb_data :
                     (mv_ok && (mv_dst == rd_b_idx))  ? mv_val  : gen_q[rd_b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q <= '0;
      shd_q <= '0;
    end else begin
      if (wb_ok)  gen_q[wb_idx] <= wb_data;
      if (mv_ok)  gen_q[mv_dst] <= mv_val;
      if (shd_ok) shd_q[wb_shd_idx] <= wb_data;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (gen_q == '0) && (shd_q == '0));

  assert_wb_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wb_ok |=> gen_q[$past(wb_idx)] == $past(wb_data));

  assert_r0_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  assert_shadow_copy_R4: assert property (@(posedge clk) disable iff (rst)
    shd_ok |=> shd_q[$past(wb_shd_idx)] == $past(wb_data));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(wb_en && wb_shd_en) |=> $stable(shd_q));

  assert_move_lands_R7: assert property (@(posedge clk) disable iff (rst)
    mv_ok |=> gen_q[$past(mv_dst)] == $past(mv_val));

  assert_wb_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_ok && mv_en && (mv_dst == wb_idx)) |=> gen_q[$past(wb_idx)] == $past(wb_data));

endmodule

// File: tb/sim_shadow_regfile.sv
`timescale 1ns/1ps
module sim_shadow_regfile;
  localparam int XLEN = 32;
  localparam int NGEN = 32;
  localparam int NSHD = 3;
  localparam int GW = 5;
  localparam int SW = 2;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst;
  logic [GW-1:0] rd_a_idx, rd_b_idx, wb_idx, mv_dst;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wb_data;
  logic wb_en, wb_shd_en, mv_en;
  logic [SW-1:0] wb_shd_idx, mv_src;
  logic [NSHD*XLEN-1:0] shd_taps;

  shadow_regfile #(.XLEN(XLEN), .NGEN(NGEN), .NSHD(NSHD)) u0 (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .wb_shd_en(wb_shd_en), .wb_shd_idx(wb_shd_idx),
    .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst),
    .shd_taps(shd_taps));

  int checks = 0, errors = 0;
  logic [XLEN-1:0] mg [NGEN];
  logic [XLEN-1:0] ms [NSHD];

  function automatic logic [XLEN-1:0] m_tap(int i);
    if (wb_en && wb_shd_en && int'(wb_shd_idx) == i) return wb_data;
    return ms[i];
  endfunction

  function automatic bit m_move();
    return mv_en && int'(mv_src) < NSHD && mv_dst != 0 && !(wb_en && wb_idx == mv_dst);
  endfunction

  function automatic logic [XLEN-1:0] m_read(int idx);
    if (idx == 0) return 0;
    if (wb_en && int'(wb_idx) == idx) return wb_data;
    if (m_move() && int'(mv_dst) == idx) return m_tap(int'(mv_src));
    return mg[idx];
  endfunction

  task automatic cmp(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit r, int ra, int rb, bit we, int wi, logic [XLEN-1:0] wd,
                      bit se, int si, bit me, int msrc, int md);
    bit do_mv, do_shd;
    logic [XLEN-1:0] mvv;
    @(negedge clk);
    rst = r; rd_a_idx = GW'(ra); rd_b_idx = GW'(rb);
    wb_en = we; wb_idx = GW'(wi); wb_data = wd; wb_shd_en = se; wb_shd_idx = SW'(si);
    mv_en = me; mv_src = SW'(msrc); mv_dst = GW'(md);
    #1;
    cmp(tag, "rd_a", rd_a_data, m_read(ra));
    cmp(tag, "rd_b", rd_b_data, m_read(rb));
    for (int i = 0; i < NSHD; i++) cmp(tag, $sformatf("tap%0d", i), shd_taps[i*XLEN +: XLEN], m_tap(i));
    do_mv = m_move();
    mvv = do_mv ? m_tap(msrc) : '0;
    do_shd = we && se && si < NSHD;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < NGEN; i++) mg[i] = 0;
      for (int i = 0; i < NSHD; i++) ms[i] = 0;
    end else begin
      if (we && wi != 0) mg[wi] = wd;
      if (do_mv) mg[md] = mvv;
      if (do_shd) ms[si] = wd;
    end
  endtask

  task automatic rd(string tag, int a, int b);
    step(tag, 0, a, b, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; wb_en = 0; wb_shd_en = 0; mv_en = 0;
    rd_a_idx = 0; rd_b_idx = 0; wb_idx = 0; wb_data = 0; wb_shd_idx = 0; mv_src = 0; mv_dst = 0;
    for (int i = 0; i < NGEN; i++) mg[i] = 0;
    for (int i = 0; i < NSHD; i++) ms[i] = 0;
    repeat (2) @(posedge clk);
    // R1 reset state
    for (int i = 0; i < NGEN; i += 2) rd("R1", i, i + 1);
    // R2 basic write and read
    step("R2", 0, 0, 0, 1, 5, 32'hA5A5_0001, 0, 0, 0, 0, 0);
    rd("R2", 5, 6);
    step("R2", 0, 0, 0, 1, 31, 32'h1234_5678, 0, 0, 0, 0, 0);
    rd("R2", 31, 5);
    // R3 register zero
    step("R3", 0, 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    rd("R3", 0, 0);
    // R4 side copy, and enable without write-back
    step("R4", 0, 7, 0, 1, 7, 32'hB0B0_0007, 1, 1, 0, 0, 0);
    rd("R4", 7, 0);
    step("R4", 0, 0, 0, 0, 3, 32'hCCCC_0002, 1, 2, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 32'h0000_F00D, 1, 2, 0, 0, 0);
    rd("R4", 0, 0);
    // R5 out-of-range shadow index
    step("R5", 0, 8, 0, 1, 8, 32'h5555_0008, 1, 3, 0, 0, 0);
    rd("R5", 8, 0);
    // R7 move and out-of-range source
    step("R7", 0, 9, 0, 0, 0, 0, 0, 0, 1, 1, 9);
    rd("R7", 9, 10);
    step("R7", 0, 10, 0, 0, 0, 0, 0, 0, 1, 3, 10);
    rd("R7", 10, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    rd("R3", 0, 0);
    // R8 write-back wins over move
    step("R8", 0, 11, 0, 1, 11, 32'hD0D0_0011, 0, 0, 1, 1, 11);
    rd("R8", 11, 0);
    // R9 forwarding of write-back and move
    step("R9", 0, 12, 12, 1, 12, 32'h9999_0012, 0, 0, 0, 0, 0);
    step("R9", 0, 13, 0, 0, 0, 0, 0, 0, 1, 2, 13);
    rd("R9", 13, 12);
    // R10 and R11 same-cycle side copy visible on taps and to move
    step("R11", 0, 14, 0, 1, 15, 32'hEEEE_0014, 1, 0, 1, 0, 14);
    rd("R11", 14, 15);
    // R6 values held across cycles and moves
    step("R6", 0, 16, 0, 0, 0, 0, 0, 0, 1, 1, 16);
    repeat (5) rd("R6", 16, 9);
    // R1 reset mid-run with activity
    step("R1", 1, 0, 0, 1, 3, 32'h1111_1111, 1, 1, 1, 0, 4);
    for (int i = 0; i < NGEN; i += 2) rd("R1", i, i + 1);
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int pick[4] = '{0, 1, 2, 31};
      int ra = ($urandom % 2) ? pick[$urandom % 4] : int'($urandom % NGEN);
      int rb = ($urandom % 2) ? pick[$urandom % 4] : int'($urandom % NGEN);
      int wi = ($urandom % 2) ? pick[$urandom % 4] : int'($urandom % NGEN);
      int md = ($urandom % 2) ? pick[$urandom % 4] : int'($urandom % NGEN);
      step("R9", ($urandom % 200) == 0, ra, rb, ($urandom % 3) != 0, wi, $urandom,
           ($urandom % 2) == 1, int'($urandom % 4), ($urandom % 3) == 0, int'($urandom % 4), md);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule